// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave side of a serial peripheral link placed in front of a byte-wide storage array. It runs on a fast system clock. Serial clock, chip select and data-in are oversampled through synchronisers. Input bits are taken on the rising serial clock and output bits change on the falling serial clock. It decodes an 8-bit command. It keeps a write-enable latch and a six-bit status field. It streams memory bytes in either direction, with a two-byte address and an automatic step to the next address.

Before each byte is committed, to the array or to the status field, the engine asks an external protection unit. It presents the target, the address and the current status byte. The unit answers with a combinational grant in the same cycle. A commit also needs the write-enable latch to be set. The data output is modelled as a value plus an output-enable. The array depth is a parameter, and addresses wrap over the whole array.

Top module: `spi_mem_engine`

## Requirements
- R1: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch is visible as bit 1 of the status byte.
- R2: A command byte other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02 changes nothing. The engine ignores every following bit and keeps the output disabled until chip select rises.
- R3: If chip select rises before the 8th command bit, no command takes effect.
- R4: Command 0x03 takes 16 address bits, MSB first, with the top bit ignored. It then returns bytes MSB first from successive addresses for as long as clocks continue, and wraps from DEPTH-1 to 0.
- R5: Command 0x02 takes 16 address bits, top bit ignored. Each data byte is committed once its 8th bit arrives, and successive bytes go to successive, wrapping addresses.
- R6: A byte is committed only while the write-enable latch is set and the protection unit grants the write. A refused byte leaves the array or status unchanged, and the address still advances.
- R7: The write-enable latch is cleared when chip select ends a command 0x02 or 0x01.
- R8: Command 0x05 returns the status byte and repeats it every further 8 clocks. Data-in is ignored throughout.
- R9: Command 0x01 takes one data byte and writes only bits 7..2 of the status byte. Data-in bits 1 and 0 are ignored.
- R10: The output enable is high only during the data phase of commands 0x03 and 0x05. It is low in standby and during the command, address and write phases.
- R11: Idle-low (mode 0) and idle-high (mode 3) serial clocks both work, provided chip select falls before the first command bit.
- R12: The status byte reads as {status bits 7..2, write-enable latch, 0}. Its reset value is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for spi_so (low means high impedance) |
| prot_req | output | 1 | One-cycle request when a byte is ready to commit |
| prot_is_status | output | 1 | The pending commit targets the status byte |
| prot_addr | output | 15 | Array address of the pending commit |
| prot_status | output | 8 | Current status byte, for the protection unit |
| prot_grant | input | 1 | Combinational permission for the pending commit |

## Verification
The bench runs the command set in both clock polarities. It uses a 16-byte array, so an address stream crosses the top of the array within a few bytes. A write stream that spans a granted and a refused address shows that refusal is decided per byte and that the address keeps stepping. A write attempted with the latch clear shows that the latch and the grant are separate gates. An address with its top bit set tells an ignored top bit apart from a decoded one. Status reads with data-in held at all ones, and a truncated command, separate proper command framing from bits that leak into the state.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int ADDR_FIELD = 15;

    localparam logic [7:0] CMD_WEL_SET  = 8'h06;
    localparam logic [7:0] CMD_WEL_CLR  = 8'h04;
    localparam logic [7:0] CMD_STAT_RD  = 8'h05;
    localparam logic [7:0] CMD_STAT_WR  = 8'h01;
    localparam logic [7:0] CMD_MEM_RD   = 8'h03;
    localparam logic [7:0] CMD_MEM_WR   = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_WDATA,
        ST_WSTAT,
        ST_RDATA,
        ST_RSTAT,
        ST_SKIP
    } eng_state_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
            prev_q <= RST_VAL;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign dout = stg_q[STAGES-1];
    assign rise = stg_q[STAGES-1] & ~prev_q;
    assign fall = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sck,
    input  logic                  spi_cs_n,
    input  logic                  spi_si,
    output logic                  spi_so,
    output logic                  spi_so_oe,
    output logic                  prot_req,
    output logic                  prot_is_status,
    output logic [ADDR_FIELD-1:0] prot_addr,
    output logic [7:0]            prot_status,
    input  logic                  prot_grant
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        eng_state_t    state;
        logic [4:0]    cnt;
        logic [15:0]   sh;
        logic          rd;
        logic [AW-1:0] addr;
        logic [7:0]    tx;
        logic          so;
        logic          wel;
        logic          wclr;
        logic [5:0]    stat;
    } regs_t;

    regs_t r_q, r_d;

    // synchronised pins: [2]=cs_n, [1]=sck, [0]=si
    logic [2:0] pin_s, pin_rise, pin_fall;
    logic       cs_s, si_s, sck_rise, sck_fall;

    spi_in_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sck, spi_si}),
        .dout  (pin_s),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign cs_s     = pin_s[2];
    assign si_s     = pin_s[0];
    assign sck_rise = pin_rise[1];
    assign sck_fall = pin_fall[1];

    logic          mem_we;
    logic          stat_we;
    logic [AW-1:0] raddr;
    logic [7:0]    mem_rdata;
    logic [15:0]   sh_next;
    logic [2:0]    bitsel;
    logic [7:0]    stat_byte;

    spi_mem_array #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (r_q.addr),
        .wdata (sh_next[7:0]),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    logic unused_bits;
    assign unused_bits = &{1'b0, pin_rise[2], pin_rise[0], pin_fall[2], pin_fall[0], sh_next};

    always_comb begin
        r_d            = r_q;
        mem_we         = 1'b0;
        stat_we        = 1'b0;
        prot_req       = 1'b0;
        prot_is_status = 1'b0;
        raddr          = r_q.addr + AW'(1);
        sh_next        = {r_q.sh[14:0], si_s};
        bitsel         = 3'd7 - r_q.cnt[2:0];
        stat_byte      = {r_q.stat, r_q.wel, 1'b0};

        if (cs_s) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.wclr  = 1'b0;
            if (r_q.wclr) begin
                r_d.wel = 1'b0;
            end
        end else begin
            case (r_q.state)
                ST_IDLE: begin
                    r_d.state = ST_OPC;
                    r_d.cnt   = '0;
                end
                ST_OPC: begin
                    if (sck_rise) begin
                        r_d.sh  = sh_next;
                        r_d.cnt = r_q.cnt + 5'd1;
                        if (r_q.cnt == 5'd7) begin
                            r_d.cnt = '0;
                            case (sh_next[7:0])
                                CMD_WEL_SET: begin
                                    r_d.wel   = 1'b1;
                                    r_d.state = ST_SKIP;
                                end
                                CMD_WEL_CLR: begin
                                    r_d.wel   = 1'b0;
                                    r_d.state = ST_SKIP;
                                end
                                CMD_STAT_RD: begin
                                    r_d.state = ST_RSTAT;
                                    r_d.tx    = stat_byte;
                                    r_d.so    = stat_byte[7];
                                end
                                CMD_STAT_WR: begin
                                    r_d.state = ST_WSTAT;
                                    r_d.wclr  = 1'b1;
                                end
                                CMD_MEM_RD: begin
                                    r_d.state = ST_ADDR;
                                    r_d.rd    = 1'b1;
                                end
                                CMD_MEM_WR: begin
                                    r_d.state = ST_ADDR;
                                    r_d.rd    = 1'b0;
                                    r_d.wclr  = 1'b1;
                                end
                                default: r_d.state = ST_SKIP;
                            endcase
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        r_d.sh  = sh_next;
                        r_d.cnt = r_q.cnt + 5'd1;
                        if (r_q.cnt == 5'd15) begin
                            r_d.cnt  = '0;
                            r_d.addr = sh_next[AW-1:0];
                            raddr    = sh_next[AW-1:0];
                            if (r_q.rd) begin
                                r_d.state = ST_RDATA;
                                r_d.tx    = mem_rdata;
                                r_d.so    = mem_rdata[7];
                            end else begin
                                r_d.state = ST_WDATA;
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (sck_rise) begin
                        r_d.sh  = sh_next;
                        r_d.cnt = r_q.cnt + 5'd1;
                        if (r_q.cnt == 5'd7) begin
                            r_d.cnt  = '0;
                            prot_req = 1'b1;
                            mem_we   = r_q.wel && prot_grant;
                            r_d.addr = r_q.addr + AW'(1);
                        end
                    end
                end
                ST_WSTAT: begin
                    if (sck_rise) begin
                        r_d.sh  = sh_next;
                        r_d.cnt = r_q.cnt + 5'd1;
                        if (r_q.cnt == 5'd7) begin
                            r_d.cnt        = '0;
                            r_d.state      = ST_SKIP;
                            prot_req       = 1'b1;
                            prot_is_status = 1'b1;
                            if (r_q.wel && prot_grant) begin
                                stat_we  = 1'b1;
                                r_d.stat = sh_next[7:2];
                            end
                        end
                    end
                end
                ST_RDATA, ST_RSTAT: begin
                    if (sck_rise) begin
                        r_d.cnt = r_q.cnt + 5'd1;
                        if (r_q.cnt == 5'd7) begin
                            r_d.cnt = '0;
                            if (r_q.state == ST_RDATA) begin
                                r_d.tx   = mem_rdata;
                                r_d.addr = r_q.addr + AW'(1);
                            end else begin
                                r_d.tx = stat_byte;
                            end
                        end
                    end else if (sck_fall) begin
                        r_d.so = r_q.tx[bitsel];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_so      = r_q.so;
    assign spi_so_oe   = (r_q.state == ST_RDATA) || (r_q.state == ST_RSTAT);
    assign prot_addr   = ADDR_FIELD'(r_q.addr);
    assign prot_status = {r_q.stat, r_q.wel, 1'b0};

endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk
    import spi_mem_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          so_oe,
    input logic          mem_we,
    input logic          stat_we,
    input logic          req,
    input logic          req_stat,
    input logic          grant,
    input logic          wel,
    input logic          wclr,
    input eng_state_t    state,
    input logic [AW-1:0] addr
);

    // R6: a byte reaches the array only with the latch set and a grant
    a_r6_commit_gated: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wel && grant));

    // R5: an array commit is announced as a memory-target request
    a_r5_commit_requested: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req && !req_stat));

    // R5: every array commit is followed by the next address
    a_r5_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr == AW'($past(addr) + AW'(1))));

    // R7: the latch is gone once a write-type command is closed
    a_r7_wel_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && wclr) |=> !wel);

    // R10: deselected means output disabled on the next cycle
    a_r10_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe);

    // R2: an ignored command never commits anything
    a_r2_skip_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!mem_we && !stat_we && !so_oe));

endmodule

bind spi_mem_engine spi_mem_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .so_oe    (spi_so_oe),
    .mem_we   (mem_we),
    .stat_we  (stat_we),
    .req      (prot_req),
    .req_stat (prot_is_status),
    .grant    (prot_grant),
    .wel      (r_q.wel),
    .wclr     (r_q.wclr),
    .state    (r_q.state),
    .addr     (r_q.addr)
);

// File: tb/sim_spi_mem_engine.sv
`timescale 1ns/1ps
module sim_spi_mem_engine;

    localparam int H = 8;   // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        so, so_oe;
    logic        prot_req, prot_is_status, prot_grant;
    logic [14:0] prot_addr;
    logic [7:0]  prot_status;
    logic        lock_stat = 1'b0;
    logic        mode3 = 1'b0;
    logic        done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // protection unit model: status writes refused while locked,
    // memory writes refused at addresses with bit 3 set when status bit 2 is set
    assign prot_grant = prot_is_status ? !lock_stat
                                       : !(prot_status[2] && prot_addr[3]);

    spi_mem_engine #(.DEPTH(16), .SYNC_STAGES(2)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .spi_sck        (sck),
        .spi_cs_n       (cs_n),
        .spi_si         (si),
        .spi_so         (so),
        .spi_so_oe      (so_oe),
        .prot_req       (prot_req),
        .prot_is_status (prot_is_status),
        .prot_addr      (prot_addr),
        .prot_status    (prot_status),
        .prot_grant     (prot_grant)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic put_bit(input logic b, output logic rb, output logic oe);
        if (mode3) begin
            sck = 1'b0;
            si  = b;
            wait_clk(H);
            rb = so; oe = so_oe;
            sck = 1'b1;
            wait_clk(H);
        end else begin
            si = b;
            wait_clk(H);
            rb = so; oe = so_oe;
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
        logic rb, oe;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            put_bit(tx[i], rb, oe);
            rx[i]  = rb;
            oe_any = oe_any | oe;
        end
    endtask

    task automatic sel();
        sck = mode3;
        wait_clk(2*H);
        cs_n = 1'b0;
        wait_clk(2*H);
    endtask

    task automatic desel();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(4*H);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] rx; logic oe;
        sel(); xfer(op, rx, oe); desel();
    endtask

    task automatic stat_read(input int n, input logic [7:0] exp, input string req);
        logic [7:0] rx; logic oe;
        sel();
        xfer(8'h05, rx, oe);
        for (int i = 0; i < n; i++) begin
            xfer(8'hFF, rx, oe);
            check(req, rx, exp);
        end
        desel();
    endtask

    task automatic stat_write(input logic [7:0] v);
        logic [7:0] rx; logic oe;
        sel(); xfer(8'h01, rx, oe); xfer(v, rx, oe); desel();
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] d [3], input int n,
                             output logic oe_seen);
        logic [7:0] rx; logic oe;
        sel();
        xfer(8'h02, rx, oe_seen);
        xfer(a[15:8], rx, oe); oe_seen |= oe;
        xfer(a[7:0], rx, oe);  oe_seen |= oe;
        for (int i = 0; i < n; i++) begin
            xfer(d[i], rx, oe); oe_seen |= oe;
        end
        desel();
    endtask

    task automatic mem_read(input logic [15:0] a, input logic [7:0] e [3], input int n,
                            input string req);
        logic [7:0] rx; logic oe;
        sel();
        xfer(8'h03, rx, oe);
        xfer(a[15:8], rx, oe);
        xfer(a[7:0], rx, oe);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, rx, oe);
            check(req, rx, e[i]);
            check({req, " oe"}, {7'd0, oe}, 8'd1);
        end
        desel();
    endtask

    task automatic t_reset();
        check("R10 oe after reset", {7'd0, so_oe}, 8'd0);
        stat_read(1, 8'h00, "R12 reset status");
    endtask

    task automatic t_latch();
        cmd1(8'h06);
        stat_read(1, 8'h02, "R1 latch set");
        cmd1(8'h04);
        stat_read(1, 8'h00, "R1 latch cleared");
    endtask

    task automatic t_abort();
        logic rb, oe;
        logic [6:0] part = 7'b0000011;
        sel();
        for (int i = 6; i >= 0; i--) put_bit(part[i], rb, oe);
        desel();
        stat_read(1, 8'h00, "R3 truncated command");
    endtask

    task automatic t_unknown();
        logic [7:0] rx; logic oe, oe_any;
        cmd1(8'h06);
        sel();
        xfer(8'hA5, rx, oe_any);
        xfer(8'h02, rx, oe); oe_any |= oe;
        xfer(8'hFF, rx, oe); oe_any |= oe;
        desel();
        check("R2 no output after unknown", {7'd0, oe_any}, 8'd0);
        stat_read(1, 8'h02, "R2 latch untouched");
        cmd1(8'h04);
    endtask

    task automatic t_write_read();
        logic oe;
        logic [7:0] d [3] = '{8'h11, 8'h22, 8'h33};
        cmd1(8'h06);
        mem_write(16'h8003, d, 3, oe);
        check("R10 oe low in write", {7'd0, oe}, 8'd0);
        stat_read(1, 8'h00, "R7 latch dropped after write");
        mem_read(16'h0003, d, 3, "R4 R5 sequential read back");
    endtask

    task automatic t_no_latch();
        logic oe;
        logic [7:0] d [3] = '{8'h5A, 8'h00, 8'h00};
        logic [7:0] e [3] = '{8'h22, 8'h00, 8'h00};
        mem_write(16'h0004, d, 1, oe);
        mem_read(16'h0004, e, 1, "R6 write without latch");
    endtask

    task automatic t_mode3_wrap();
        logic oe;
        logic [7:0] d [3] = '{8'hA1, 8'hA2, 8'hA3};
        logic [7:0] e [3] = '{8'hA2, 8'hA3, 8'h11};
        logic [7:0] f [3] = '{8'h11, 8'h22, 8'h00};
        mode3 = 1'b1;
        cmd1(8'h06);
        mem_write(16'h000E, d, 3, oe);
        mem_read(16'h000F, e, 2, "R4 R11 wrap read mode 3");
        mem_read(16'h0003, f, 2, "R11 mode 3 read");
        mode3 = 1'b0;
    endtask

    task automatic t_status();
        cmd1(8'h06);
        stat_write(8'hFF);
        stat_read(3, 8'hFC, "R8 R9 R7 status repeat");
        cmd1(8'h06);
        stat_read(1, 8'hFE, "R12 latch in status");
        stat_write(8'h06);
        stat_read(1, 8'h04, "R9 low bits ignored");
    endtask

    task automatic t_protect();
        logic oe;
        logic [7:0] d [3] = '{8'h77, 8'h78, 8'h00};
        logic [7:0] e [3] = '{8'hA2, 8'h78, 8'h00};
        cmd1(8'h06);
        mem_write(16'h000F, d, 2, oe);
        mem_read(16'h000F, e, 2, "R6 per-byte grant");
        lock_stat = 1'b1;
        cmd1(8'h06);
        stat_write(8'h00);
        stat_read(1, 8'h04, "R6 status write refused");
        lock_stat = 1'b0;
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_latch();
        t_abort();
        t_unknown();
        t_write_read();
        t_no_latch();
        t_mode3_wrap();
        t_status();
        t_protect();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule